// File: doc/BRIEF.md
# Interrupt Arbitration Gate

This block decides, every cycle, whether a hart has to take an interrupt and which one. It takes the pending and enable vectors, a per-interrupt flag that hands the interrupt to supervisor handling, the current privilege level and the two global interrupt-enable bits. It returns a take flag and the cause index of the winner.

Each interrupt line is qualified in one of two ways. A line handed to supervisor handling is qualified by the supervisor global enable. Any other line is qualified by the machine global enable. Each enable only counts at its own privilege level. Below that level it is treated as set, and above it the enable is forced off. Among the lines that qualify, the lowest index wins.

The result is registered by default, so it follows its inputs by one clock. A parameter can remove the register for a purely combinational path. The pending and enable storage, trap entry and vectored dispatch belong to other blocks.

Top module: `irq_sel_top`

## Requirements
- R1: A line is a candidate only when its bit is set in both the pending input and the enable input. A pending line whose enable bit is clear is never reported.
- R2: A line whose delegation bit is 0 qualifies under two conditions. One is privilege U (encoded 0) or S (encoded 1), whatever the machine enable says. The other is privilege M (encoded 3) with the machine enable at 1.
- R3: A line whose delegation bit is 1 qualifies at privilege U whatever the supervisor enable says. At privilege S it needs the supervisor enable at 1. At privilege M it never qualifies, even with both enables at 1.
- R4: When several lines qualify, the cause output gives the lowest qualifying index (bit 0 has the highest priority).
- R5: When no line qualifies, the take output is 0 and the cause output is 0.
- R6: With the default registered output, take and cause reflect the inputs sampled at the previous rising clock edge. A new input set can be applied every cycle.
- R7: While reset is asserted (active low), take is 0 and cause is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | NUM_IRQ | Pending interrupt lines |
| en_i | input | NUM_IRQ | Per-line enables |
| deleg_i | input | NUM_IRQ | 1 = line is handled at supervisor level |
| priv_i | input | 2 | Current privilege: 0 = U, 1 = S, 3 = M |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt must be taken |
| cause_o | output | $clog2(NUM_IRQ) | Index of the winning line, 0 when none |

## Verification
The hardest case to reach is a mix of both delegation classes with a low-index line that is pending and enabled but disqualified by its class. Here the winner has to skip past that line to a higher index in the other class. Random vectors rarely produce it with the privilege and enable bits set just right. Directed vectors build it on purpose, for example a delegated line 2 at privilege S with the supervisor enable clear beside an undelegated line 9. A long random stream with dense pending and enable words then covers the other combinations of privilege, delegation and global enables back to back.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
   typedef enum logic [1:0] {
      PRIV_U    = 2'b00,
      PRIV_S    = 2'b01,
      PRIV_RSVD = 2'b10,
      PRIV_M    = 2'b11
   } priv_e;
endpackage

// File: rtl/irq_sel_gate.sv
module irq_sel_gate
   import irq_sel_pkg::*;
#(
   parameter int NUM_IRQ = 32
) (
   input  logic [NUM_IRQ-1:0] pend,
   input  logic [NUM_IRQ-1:0] en,
   input  logic [NUM_IRQ-1:0] deleg,
   input  priv_e              priv,
   input  logic               mie,
   input  logic               sie,
   output logic [NUM_IRQ-1:0] elig
);
   logic m_on;
   logic s_on;

   // Machine class: open below M, gated by mie at M.
   assign m_on = (priv != PRIV_M) || mie;
   // Supervisor class: open at U, gated by sie at S, closed above S.
   assign s_on = (priv == PRIV_U) || ((priv == PRIV_S) && sie);

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
      assign elig[g] = pend[g] & en[g] & (deleg[g] ? s_on : m_on);
   end
endmodule

// File: rtl/irq_sel_prio.sv
module irq_sel_prio #(
   parameter int NUM_IRQ = 32,
   parameter int IDX_W   = $clog2(NUM_IRQ)
) (
   input  logic [NUM_IRQ-1:0] vec,
   output logic               found,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      idx = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
   assign found = |vec;
endmodule

// File: rtl/irq_sel_top.sv
module irq_sel_top
   import irq_sel_pkg::*;
#(
   parameter int  NUM_IRQ = 32,
   parameter bit  REG_OUT = 1'b1,
   localparam int CAUSE_W = $clog2(NUM_IRQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] pend_i,
   input  logic [NUM_IRQ-1:0] en_i,
   input  logic [NUM_IRQ-1:0] deleg_i,
   input  logic [1:0]         priv_i,
   input  logic               mie_i,
   input  logic               sie_i,
   output logic               take_o,
   output logic [CAUSE_W-1:0] cause_o
);
   if (NUM_IRQ < 2 || NUM_IRQ > 64) begin : g_bad_width
      $error("irq_sel_top: NUM_IRQ must lie in 2..64");
   end

   logic [NUM_IRQ-1:0] elig;
   logic               hit;
   logic [CAUSE_W-1:0] win;

   irq_sel_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
      .pend  (pend_i),
      .en    (en_i),
      .deleg (deleg_i),
      .priv  (priv_e'(priv_i)),
      .mie   (mie_i),
      .sie   (sie_i),
      .elig  (elig)
   );

   irq_sel_prio #(.NUM_IRQ(NUM_IRQ), .IDX_W(CAUSE_W)) u_prio (
      .vec   (elig),
      .found (hit),
      .idx   (win)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            take_o  <= 1'b0;
            cause_o <= '0;
         end else begin
            take_o  <= hit;
            cause_o <= win;
         end
      end
   end else begin : g_comb
      assign take_o  = hit;
      assign cause_o = win;
   end
endmodule

// File: rtl/irq_sel_chk.sv
module irq_sel_chk #(
   parameter int  NUM_IRQ = 32,
   parameter bit  REG_OUT = 1'b1,
   localparam int CAUSE_W = $clog2(NUM_IRQ)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_IRQ-1:0] pend_i,
   input logic [NUM_IRQ-1:0] en_i,
   input logic [NUM_IRQ-1:0] deleg_i,
   input logic [1:0]         priv_i,
   input logic               mie_i,
   input logic               sie_i,
   input logic               take_o,
   input logic [CAUSE_W-1:0] cause_o
);
   localparam logic [NUM_IRQ-1:0] ONE = {{(NUM_IRQ-1){1'b0}}, 1'b1};

   assert_idle_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !take_o |-> (cause_o == '0));

   if (REG_OUT) begin : g_seq
      assert_winner_candidate_R1: assert property (@(posedge clk) disable iff (!rst_n)
         take_o |-> (($past(pend_i & en_i) & (ONE << cause_o)) != '0));

      assert_no_cand_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(pend_i & en_i) == '0) |-> !take_o);

      assert_m_needs_mie_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (take_o && ($past(priv_i) == 2'b11)) |-> $past(mie_i));

      assert_m_blocks_deleg_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (take_o && ($past(priv_i) == 2'b11)) |-> (($past(deleg_i) & (ONE << cause_o)) == '0));

      assert_s_deleg_needs_sie_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (take_o && ($past(priv_i) == 2'b01) && (($past(deleg_i) & (ONE << cause_o)) != '0))
         |-> $past(sie_i));
   end
endmodule

bind irq_sel_top irq_sel_chk #(.NUM_IRQ(NUM_IRQ), .REG_OUT(REG_OUT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pend_i  (pend_i),
   .en_i    (en_i),
   .deleg_i (deleg_i),
   .priv_i  (priv_i),
   .mie_i   (mie_i),
   .sie_i   (sie_i),
   .take_o  (take_o),
   .cause_o (cause_o)
);

// File: tb/irq_sel_top_bench.sv
module irq_sel_top_bench;
   localparam int N = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pend_i = '0;
   logic [N-1:0] en_i = '0;
   logic [N-1:0] deleg_i = '0;
   logic [1:0]   priv_i = 2'b11;
   logic         mie_i = 1'b0;
   logic         sie_i = 1'b0;
   logic         take_o;
   logic [4:0]   cause_o;

   typedef struct {
      logic       take;
      logic [4:0] cause;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   irq_sel_top u_irq_sel_top (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_i  (pend_i),
      .en_i    (en_i),
      .deleg_i (deleg_i),
      .priv_i  (priv_i),
      .mie_i   (mie_i),
      .sie_i   (sie_i),
      .take_o  (take_o),
      .cause_o (cause_o)
   );

   // Priority model built from the requirements.
   function automatic exp_t model(input logic [N-1:0] p, input logic [N-1:0] e,
                                  input logic [N-1:0] d, input logic [1:0] pr,
                                  input logic mi, input logic si);
      exp_t r;
      logic m_ok, s_ok;
      m_ok = (pr == 2'd0) || (pr == 2'd1) || (pr == 2'd3 && mi);
      s_ok = (pr == 2'd0) || (pr == 2'd1 && si);
      r.take = 1'b0;
      r.cause = '0;
      r.tag = "";
      for (int i = 0; i < N; i++) begin
         if (!r.take && p[i] && e[i] && (d[i] ? s_ok : m_ok)) begin
            r.take = 1'b1;
            r.cause = 5'(i);
         end
      end
      return r;
   endfunction

   task automatic apply(input logic [N-1:0] p, input logic [N-1:0] e,
                        input logic [N-1:0] d, input logic [1:0] pr,
                        input logic mi, input logic si, input string tag);
      exp_t x;
      @(negedge clk);
      pend_i = p; en_i = e; deleg_i = d; priv_i = pr; mie_i = mi; sie_i = si;
      x = model(p, e, d, pr, mi, si);
      x.tag = tag;
      exp_q.push_back(x);
   endtask

   // Monitor: one result per cycle, one clock after the inputs were driven.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t x;
            x = exp_q.pop_front();
            n_vec++;
            if (take_o !== x.take || cause_o !== x.cause) begin
               n_bad++;
               $display("FAIL %s: got take=%0b cause=%0d, expected take=%0b cause=%0d",
                        x.tag, take_o, cause_o, x.take, x.cause);
            end
         end
      end
   end

   initial begin
      logic [1:0] privs [3];
      privs[0] = 2'd0; privs[1] = 2'd1; privs[2] = 2'd3;
      pend_i = '1; en_i = '1;
      repeat (3) @(negedge clk);
      n_vec++;
      if (take_o !== 1'b0 || cause_o !== 5'd0) begin
         n_bad++;
         $display("FAIL R7: got take=%0b cause=%0d, expected take=0 cause=0", take_o, cause_o);
      end
      pend_i = '0; en_i = '0;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      apply('0, '1, '0, 2'd0, 1'b1, 1'b1, "R5 nothing pending");
      apply(32'h0000_00F0, 32'h0000_000F, '0, 2'd0, 1'b1, 1'b1, "R1 pending but disabled");
      apply(32'h0000_0030, 32'h0000_0020, '0, 2'd0, 1'b0, 1'b0, "R1 enable selects bit 5");
      apply(32'h0000_0100, '1, '0, 2'd3, 1'b0, 1'b1, "R2 M with mie clear");
      apply(32'h0000_0100, '1, '0, 2'd3, 1'b1, 1'b0, "R2 M with mie set");
      apply(32'h0000_0100, '1, '0, 2'd1, 1'b0, 1'b0, "R2 S ignores mie");
      apply(32'h0000_0100, '1, '0, 2'd0, 1'b0, 1'b0, "R2 U ignores mie");
      apply(32'h0000_0040, '1, 32'h0000_0040, 2'd0, 1'b0, 1'b0, "R3 U ignores sie");
      apply(32'h0000_0040, '1, 32'h0000_0040, 2'd1, 1'b1, 1'b0, "R3 S with sie clear");
      apply(32'h0000_0040, '1, 32'h0000_0040, 2'd1, 1'b0, 1'b1, "R3 S with sie set");
      apply(32'h0000_0040, '1, 32'h0000_0040, 2'd3, 1'b1, 1'b1, "R3 M blocks delegated");
      apply(32'h8000_0020, '1, '0, 2'd3, 1'b1, 1'b0, "R4 bit 5 over bit 31");
      apply(32'h8000_0001, '1, '0, 2'd3, 1'b1, 1'b0, "R4 bit 0 wins");
      apply(32'h8000_0000, '1, '0, 2'd3, 1'b1, 1'b0, "R4 only bit 31");
      apply(32'h0000_0204, '1, 32'h0000_0004, 2'd1, 1'b0, 1'b0, "R3 skip delegated 2 to 9");
      apply(32'h0000_0204, '1, 32'h0000_0200, 2'd3, 1'b1, 1'b1, "R2 skip delegated 9 to 2");
      apply(32'hFFFF_FFFF, '1, '1, 2'd3, 1'b1, 1'b1, "R5 all delegated at M");

      for (int k = 0; k < 3000; k++) begin
         apply($urandom & $urandom, $urandom | $urandom, $urandom, privs[$urandom % 3],
               1'($urandom), 1'($urandom), "R6 back-to-back random");
      end

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, got hang, expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule